// File: doc/BRIEF.md
# Sectioned Manchester Carry-Chain Adder with Section Bypass

This block adds two WIDTH-bit unsigned operands and a carry-in, and gives a WIDTH-bit sum and a carry-out. The operands are split into 4-bit sections. Each bit forms its own generate, propagate and kill terms. Inside a section the carry moves bit by bit through a mux-style chain: a propagating bit passes its incoming carry on, and any other bit replaces it with its own generate value.

Each section builds its carry-out from three mutually exclusive select terms. The first passes the chain result through bit 3 when bit 3 propagates but the lower three bits do not all propagate. The second uses bit 3's own generate/kill result when bit 3 does not propagate. The third is a bypass that forwards the section carry-in when all four bits propagate.

Sections are cascaded, and section 0 takes the external carry-in. The datapath is purely combinational. A parameter can add one output register stage.

Top module: `mca_adder`

## Requirements
- R1: When a bit has both operand bits at 1 (generate), that bit's carry-out is 1 whatever its incoming carry.
- R2: When a bit has both operand bits at 0 (kill), that bit's carry-out is 0 whatever its incoming carry.
- R3: When exactly one operand bit is 1 (propagate), the bit's carry-out equals its incoming carry.
- R4: In every section, exactly one of the three carry-out selects (chain, bit-3 generate/kill, bypass) is active for every input pattern.
- R5: When all four bits of a section propagate, the section carry-out equals the section carry-in.
- R6: Sum bit i is the propagate of bit i XOR that bit's incoming carry, so {cout_o, sum_o} equals a_i + b_i + cin_i, taken over WIDTH+1 bits.
- R7: Section 0 takes cin_i and section k takes the carry-out of section k-1. A carry generated or injected at bit 0 reaches cout_o through every section (for example a_i = 0…01, b_i = all ones).
- R8: With REG_OUT = 1, sum_o and cout_o show the result for the inputs present at the previous rising clock edge, and they read 0 while rst_ni is low. With REG_OUT = 0, the outputs follow the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register and the checks |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry-in to section 0 |
| sum_o | output | WIDTH | Sum |
| cout_o | output | 1 | Carry-out of the last section |

## Verification
The following are checked on every clock edge, for each bit and section:
- the generate, kill and propagate carry rules;
- the single active carry-out select;
- the bypass equality;
- in combinational mode, the match of the full result with the arithmetic sum.

Some behaviour only the bench scenarios can show:
- the cross-section carry travelling the full width on the worst-case ripple pattern;
- patterns where many sections bypass at once;
- the one-cycle latency and the reset value of the registered variant, which runs beside the combinational instance.

// File: rtl/mca_pkg.sv
package mca_pkg;
  localparam int unsigned SEC_W = 4;

  typedef struct packed {
    logic chain;  // carry leaves through bit 3's chain
    logic gk;     // bit 3 generates or kills
    logic byp;    // section skipped
  } sec_sel_t;
endpackage

// File: rtl/mca_bit_cell.sv
module mca_bit_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic p_o,
  output logic g_o,
  output logic k_o,
  output logic c_o,
  output logic s_o
);
  always_comb begin
    g_o = a_i & b_i;
    p_o = a_i ^ b_i;
    k_o = ~a_i & ~b_i;
    c_o = p_o ? c_i : g_o;
    s_o = p_o ^ c_i;
  end
endmodule

// File: rtl/mca_section.sv
module mca_section
  import mca_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEC_W-1:0] a_i,
  input  logic [SEC_W-1:0] b_i,
  input  logic             cin_i,
  output logic [SEC_W-1:0] sum_o,
  output logic             cout_o
);
  logic [SEC_W-1:0] p, g, k;
  logic [SEC_W:0]   c;
  sec_sel_t         sel;

  assign c[0] = cin_i;

  for (genvar i = 0; i < SEC_W; i++) begin : g_bit
    mca_bit_cell u_cell (
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .c_i (c[i]),
      .p_o (p[i]),
      .g_o (g[i]),
      .k_o (k[i]),
      .c_o (c[i+1]),
      .s_o (sum_o[i])
    );

    AST_BIT_GEN:  assert property (@(posedge clk_i) disable iff (!rst_ni)
                    g[i] |-> c[i+1]);                       // R1
    AST_BIT_KILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    k[i] |-> !c[i+1]);                      // R2
    AST_BIT_PROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    p[i] |-> (c[i+1] == c[i]));             // R3
  end

  // conflict-free three-way selection of the section carry-out
  always_comb begin
    sel.chain = ~(p[0] & p[1] & p[2]) & p[3];
    sel.gk    = ~p[3];
    sel.byp   = p[0] & p[1] & p[2] & p[3];
    cout_o    = (sel.chain & c[SEC_W]) | (sel.gk & g[SEC_W-1]) | (sel.byp & cin_i);
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    $countones(sel) == 1);                  // R4
  AST_BYPASS:     assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (&p) |-> (cout_o == cin_i));            // R5
endmodule

// File: rtl/mca_adder.sv
module mca_adder
  import mca_pkg::*;
#(
  parameter int unsigned WIDTH   = 32,
  parameter bit          REG_OUT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int unsigned NSEC = WIDTH / SEC_W;

  if (WIDTH % SEC_W != 0 || WIDTH == 0) begin : g_bad_width
    $error("WIDTH must be a nonzero multiple of the section width");
  end

  logic [NSEC:0]    sc;
  logic [WIDTH-1:0] sum_c;

  assign sc[0] = cin_i;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    mca_section u_sec (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .a_i    (a_i[s*SEC_W +: SEC_W]),
      .b_i    (b_i[s*SEC_W +: SEC_W]),
      .cin_i  (sc[s]),
      .sum_o  (sum_c[s*SEC_W +: SEC_W]),
      .cout_o (sc[s+1])
    );
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sum_o  <= '0;
        cout_o <= 1'b0;
      end else begin
        sum_o  <= sum_c;
        cout_o <= sc[NSEC];
      end
    end
  end else begin : g_comb
    assign sum_o  = sum_c;
    assign cout_o = sc[NSEC];

    AST_SUM_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
                     {cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i})); // R6
  end
endmodule

// File: tb/mca_adder_test.sv
module mca_adder_test;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum_c, sum_r;
  logic         cout_c, cout_r;

  int errors = 0;
  int checks = 0;
  logic [W:0] exp_prev = '0;
  bit         have_prev = 1'b0;

  always #5 clk = ~clk;

  mca_adder #(.WIDTH(W), .REG_OUT(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum_c), .cout_o(cout_c));

  mca_adder #(.WIDTH(W), .REG_OUT(1'b1)) uut_reg (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum_r), .cout_o(cout_r));

  function automatic logic [W:0] model(logic [W-1:0] x, logic [W-1:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  task automatic check(string tag, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive after negedge; registered instance is checked against the previous vector
  task automatic apply(string tag, logic [W-1:0] x, logic [W-1:0] y, logic ci);
    @(negedge clk);
    if (have_prev) check("R8 registered", {cout_r, sum_r}, exp_prev);
    a = x; b = y; cin = ci;
    #1;
    check(tag, {cout_c, sum_c}, model(x, y, ci));
    exp_prev  = model(x, y, ci);
    have_prev = 1'b1;
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] x, y, m;
    void'($urandom(32'd4711));
    a = 32'h1234_5678; b = 32'hFFFF_0000; cin = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset", {cout_r, sum_r}, '0);
    check("R8 comb during reset", {cout_c, sum_c}, model(a, b, cin));
    rst_n = 1'b1;

    apply("R1 all generate",        '1, '1, 1'b0);
    apply("R2 all kill",            '0, '0, 1'b1);
    apply("R3 all propagate cin=1", 32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1);
    apply("R5 all bypass cin=0",    32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b0);
    apply("R7 worst ripple",        32'h0000_0001, '1, 1'b0);
    apply("R7 cin ripple",          '0, '1, 1'b1);
    apply("R4 bit3 chain mix",      32'h8888_8888, 32'h0101_0101, 1'b1);
    apply("R6 zero",                '0, '0, 1'b0);
    apply("R1 msb generate",        32'h8000_0000, 32'h8000_0000, 1'b0);

    for (int n = 0; n < 400; n++) begin
      x = $urandom();
      y = $urandom();
      if (n % 3 == 0) begin
        // force random sections into full propagate
        m = $urandom();
        for (int s = 0; s < W / 4; s++)
          if (m[s]) y[s*4 +: 4] = ~x[s*4 +: 4];
      end
      apply(n % 3 == 0 ? "R5 random bypass mix" : "R6 random", x, y, 1'($urandom()));
    end

    apply("R6 flush", '0, '0, 1'b0);
    @(negedge clk);
    check("R8 last registered", {cout_r, sum_r}, exp_prev);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule